// File: doc/BRIEF.md
# Voice Wake Sequencing Controller

This block sequences an always-on voice wake flow for a low-power audio processor. It does no signal processing itself. It reacts to a speech flag from a voice activity detector, to match and reject results from a keyword engine, and to host commands. It drives the enables and the power request that decide which engines run.

The flow has three tiers. While listening, only the detector runs and the block asks for a low-power, slow-clocked core. Speech moves the block into a keyword check. A recognised keyword opens a command window. A reject, or a check that runs too long, drops the block back to listening. The command window closes on a host done pulse or after a run of cycles with no command activity. A host off input parks everything in an off state until the host releases it.

Top module: `voice_wake_seq`

## Requirements
- R1: Synchronous active-high reset places the block in the listening state: `lp_req`=1, `vad_en`=1, `kw_en`=0, `cmd_mode`=0, `host_irq`=0.
- R2: In listening, `speech` high (with `host_off` low) moves the block to the keyword check on that clock edge: the following cycle shows `kw_en`=1, `vad_en`=0, `lp_req`=0.
- R3: In the keyword check, `kw_match` high moves the block to command mode (`cmd_mode`=1, `kw_en`=0). `kw_match` wins over `kw_reject` in the same cycle.
- R4: In the keyword check, `kw_reject` high without `kw_match` returns the block to listening on that edge.
- R5: The keyword check lasts at most `kw_limit` cycles. After `kw_limit` cycles in the check with no match or reject, the block is listening again. A limit of 0 acts as 1.
- R6: On each entry into command mode, `host_irq` is high for exactly one cycle, the first cycle of `cmd_mode`. It is low at all other times.
- R7: In command mode, a `host_done` pulse returns the block to listening on that edge. `host_done` wins over `cmd_act`.
- R8: Command mode ends after `cmd_limit` consecutive cycles with neither `cmd_act` nor `host_done`. Any `cmd_act` restarts that count. A limit of 0 acts as 1.
- R9: A `speech` pulse during the keyword check has no effect. It does not restart the check's timeout, so the check still ends `kw_limit` cycles after it began.
- R10: `host_off` high forces the off state from any state on the next edge: `vad_en`=`kw_en`=`cmd_mode`=0, `lp_req`=1. In off, `speech` is ignored. Releasing `host_off` returns the block to listening.
- R11: At most one of `vad_en`, `kw_en`, `cmd_mode` is high. `lp_req` is high exactly in the off and listening states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_off | input | 1 | Host disable; holds the block in off |
| speech | input | 1 | Speech flag from the activity detector |
| kw_match | input | 1 | Keyword engine recognised the wake word |
| kw_reject | input | 1 | Keyword engine rejected the utterance |
| cmd_act | input | 1 | Command activity; restarts inactivity count |
| host_done | input | 1 | Host ends command mode |
| kw_limit | input | CNT_W | Keyword check length in cycles |
| cmd_limit | input | CNT_W | Command inactivity length in cycles |
| lp_req | output | 1 | Low-power / slow-clock request |
| vad_en | output | 1 | Activity detector enable |
| kw_en | output | 1 | Keyword engine enable |
| cmd_mode | output | 1 | Command interpretation mode |
| host_irq | output | 1 | One-cycle pulse on command-mode entry |

## Verification
Every output is registered from the next state. An input held across clock edge k therefore shows its effect in the cycle after edge k, and only there. The driver applies one input set per falling edge and pushes the outputs that the reference model predicts for the following cycle. The monitor pops each entry just after the next rising edge and compares it. Timeouts are checked cycle by cycle, so a window that ends one cycle early or late shows up as a miscompare at the exact cycle.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_LISTEN = 2'd1,
    ST_KWCHK  = 2'd2,
    ST_CMD    = 2'd3
  } wake_st_t;
endpackage

// File: rtl/vws_timer.sv
// Cycle counter held at zero outside its owning state; flags expiry when the
// current cycle is the last one allowed by the limit (limit 0 behaves as 1).
module vws_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt;

  always_comb begin
    expired = ({1'b0, cnt} + EW'(1)) >= {1'b0, limit};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    (!clear && !expired) |=> (cnt != '0));
endmodule

// File: rtl/vws_fsm.sv
module vws_fsm
  import vws_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     host_off,
  input  logic     speech,
  input  logic     kw_match,
  input  logic     kw_reject,
  input  logic     cmd_act,
  input  logic     host_done,
  input  logic     kw_exp,
  input  logic     cmd_exp,
  output wake_st_t st,
  output logic     lp_req,
  output logic     vad_en,
  output logic     kw_en,
  output logic     cmd_mode,
  output logic     host_irq
);
  wake_st_t nxt;

  always_comb begin
    nxt = st;
    if (host_off) begin
      nxt = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF:    nxt = ST_LISTEN;
        ST_LISTEN: if (speech) nxt = ST_KWCHK;
        ST_KWCHK: begin
          if (kw_match)                nxt = ST_CMD;
          else if (kw_reject || kw_exp) nxt = ST_LISTEN;
        end
        ST_CMD: begin
          if (host_done)                nxt = ST_LISTEN;
          else if (!cmd_act && cmd_exp) nxt = ST_LISTEN;
        end
        default: nxt = ST_LISTEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_LISTEN;
      lp_req   <= 1'b1;
      vad_en   <= 1'b1;
      kw_en    <= 1'b0;
      cmd_mode <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      st       <= nxt;
      lp_req   <= (nxt == ST_OFF) || (nxt == ST_LISTEN);
      vad_en   <= (nxt == ST_LISTEN);
      kw_en    <= (nxt == ST_KWCHK);
      cmd_mode <= (nxt == ST_CMD);
      host_irq <= (nxt == ST_CMD) && (st != ST_CMD);
    end
  end

  // R2: speech while listening opens the keyword check
  a_r2_speech_wakes: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LISTEN && speech && !host_off) |=> kw_en);
  // R3: a match during the check opens command mode
  a_r3_match_to_cmd: assert property (@(posedge clk) disable iff (rst)
    (st == ST_KWCHK && kw_match && !host_off) |=> cmd_mode);
  // R4: a lone reject returns to listening
  a_r4_reject_listen: assert property (@(posedge clk) disable iff (rst)
    (st == ST_KWCHK && kw_reject && !kw_match && !host_off) |=> vad_en);
  // R7: host done closes command mode
  a_r7_done_listen: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMD && host_done && !host_off) |=> (vad_en && !cmd_mode));
  // R10: speech in off is ignored while the host holds off
  a_r10_off_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF && host_off) |=> (st == ST_OFF));
endmodule

// File: rtl/voice_wake_seq.sv
module voice_wake_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_off,
  input  logic             speech,
  input  logic             kw_match,
  input  logic             kw_reject,
  input  logic             cmd_act,
  input  logic             host_done,
  input  logic [CNT_W-1:0] kw_limit,
  input  logic [CNT_W-1:0] cmd_limit,
  output logic             lp_req,
  output logic             vad_en,
  output logic             kw_en,
  output logic             cmd_mode,
  output logic             host_irq
);
  import vws_pkg::*;

  wake_st_t st;
  logic     kw_exp;
  logic     cmd_exp;
  logic     kw_clr;
  logic     cmd_clr;

  always_comb begin
    kw_clr  = (st != ST_KWCHK);
    cmd_clr = (st != ST_CMD) || cmd_act;
  end

  vws_timer #(.CNT_W(CNT_W)) u_kw_timer (
    .clk(clk), .rst(rst), .clear(kw_clr), .limit(kw_limit), .expired(kw_exp)
  );

  vws_timer #(.CNT_W(CNT_W)) u_cmd_timer (
    .clk(clk), .rst(rst), .clear(cmd_clr), .limit(cmd_limit), .expired(cmd_exp)
  );

  vws_fsm u_fsm (
    .clk(clk), .rst(rst), .host_off(host_off), .speech(speech),
    .kw_match(kw_match), .kw_reject(kw_reject), .cmd_act(cmd_act),
    .host_done(host_done), .kw_exp(kw_exp), .cmd_exp(cmd_exp), .st(st),
    .lp_req(lp_req), .vad_en(vad_en), .kw_en(kw_en), .cmd_mode(cmd_mode),
    .host_irq(host_irq)
  );

  // R6: the interrupt lasts one cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
    host_irq |=> !host_irq);
  // R6: the interrupt marks the first cycle of command mode
  a_r6_irq_on_entry: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> (cmd_mode && !$past(cmd_mode)));
  // R10: host off clears every engine enable
  a_r10_off_disables: assert property (@(posedge clk) disable iff (rst)
    host_off |=> (!vad_en && !kw_en && !cmd_mode && lp_req));
  // R11: engine enables are mutually exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vad_en, kw_en, cmd_mode}));
  // R11: low-power request only while no keyword or command engine runs
  a_r11_lp_idle: assert property (@(posedge clk) disable iff (rst)
    lp_req |-> (!kw_en && !cmd_mode));
endmodule

// File: tb/tb_voice_wake_seq.sv
`timescale 1ns/1ps
module tb_voice_wake_seq;
  localparam int CNT_W = 16;
  localparam int M_OFF = 0, M_LIS = 1, M_KW = 2, M_CMD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_off = 0, speech = 0, kw_match = 0, kw_reject = 0, cmd_act = 0, host_done = 0;
  logic [CNT_W-1:0] kw_limit = 16'd5, cmd_limit = 16'd4;
  logic lp_req, vad_en, kw_en, cmd_mode, host_irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  int mst = M_LIS;
  int mcnt = 0;

  always #5 clk = ~clk;

  voice_wake_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .host_off(host_off), .speech(speech),
    .kw_match(kw_match), .kw_reject(kw_reject), .cmd_act(cmd_act),
    .host_done(host_done), .kw_limit(kw_limit), .cmd_limit(cmd_limit),
    .lp_req(lp_req), .vad_en(vad_en), .kw_en(kw_en), .cmd_mode(cmd_mode),
    .host_irq(host_irq)
  );

  function automatic logic [4:0] outs_of(int s, bit irq);
    return {(s == M_OFF || s == M_LIS), (s == M_LIS), (s == M_KW), (s == M_CMD), irq};
  endfunction

  // Driver: one input set per falling edge; reference model predicts next-cycle outputs.
  task automatic step(bit off, bit sp, bit m, bit rj, bit a, bit d, string tag);
    int nxt;
    int lim;
    @(negedge clk);
    host_off = off; speech = sp; kw_match = m; kw_reject = rj; cmd_act = a; host_done = d;
    nxt = mst;
    if (off) nxt = M_OFF;
    else case (mst)
      M_OFF: nxt = M_LIS;
      M_LIS: if (sp) nxt = M_KW;
      M_KW: begin
        lim = (kw_limit == 0) ? 1 : int'(kw_limit);
        if (m) nxt = M_CMD;
        else if (rj || (mcnt + 1 >= lim)) nxt = M_LIS;
      end
      default: begin
        lim = (cmd_limit == 0) ? 1 : int'(cmd_limit);
        if (d) nxt = M_LIS;
        else if (!a && (mcnt + 1 >= lim)) nxt = M_LIS;
      end
    endcase
    exp_q.push_back(outs_of(nxt, nxt == M_CMD && mst != M_CMD));
    tag_q.push_back(tag);
    if (nxt != mst || (mst == M_CMD && a)) mcnt = 0;
    else mcnt = mcnt + 1;
    mst = nxt;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {lp_req, vad_en, kw_en, cmd_mode, host_irq};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: {lp,vad,kw,cmd,irq} actual=%b expected=%b at %0t", t, g, e, $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    checks++;
    if ({lp_req, vad_en, kw_en, cmd_mode, host_irq} !== 5'b11000) begin
      fails++;
      $display("FAIL R1: actual=%b expected=%b", {lp_req, vad_en, kw_en, cmd_mode, host_irq}, 5'b11000);
    end
    idle(2, "R1 listen holds");
    // R2 then R3/R6: speech, match -> command with interrupt
    step(0, 1, 0, 0, 0, 0, "R2 speech to check");
    idle(1, "R5 check running");
    step(0, 0, 1, 0, 0, 0, "R3 R6 match to cmd");
    step(0, 0, 0, 0, 1, 0, "R8 activity");
    step(0, 0, 0, 0, 0, 1, "R7 host done");
    // R4: reject
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    step(0, 0, 0, 1, 0, 0, "R4 reject to listen");
    // R3: match beats reject
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    step(0, 0, 1, 1, 0, 0, "R3 match wins");
    idle(6, "R8 inactivity timeout");
    // R5 + R9: timeout with speech pulses inside the check
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    step(0, 1, 0, 0, 0, 0, "R9 speech ignored");
    idle(1, "R5 check");
    step(0, 1, 0, 0, 0, 0, "R9 speech ignored");
    idle(3, "R5 check timeout");
    // R8: activity restarts inactivity count
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    step(0, 0, 1, 0, 0, 0, "R6 irq again");
    idle(2, "R8 counting");
    step(0, 0, 0, 0, 1, 0, "R8 restart");
    idle(5, "R8 timeout after restart");
    // R7: done wins over activity
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    step(0, 0, 1, 0, 0, 0, "R3 match");
    step(0, 0, 0, 0, 1, 1, "R7 done beats activity");
    // R5 limit zero acts as one
    @(negedge clk); kw_limit = 16'd0;
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    idle(2, "R5 zero limit");
    @(negedge clk); kw_limit = 16'd5;
    // R10: off from command mode; speech ignored; release
    step(0, 1, 0, 0, 0, 0, "R2 speech");
    step(0, 0, 1, 0, 0, 0, "R3 match");
    step(1, 0, 0, 0, 0, 0, "R10 force off");
    step(1, 1, 0, 0, 0, 0, "R10 speech ignored in off");
    step(1, 0, 1, 0, 0, 0, "R10 match ignored in off");
    step(0, 0, 0, 0, 0, 0, "R10 release to listen");
    step(0, 1, 0, 0, 0, 0, "R2 speech after off");
    step(1, 0, 0, 0, 0, 0, "R10 off from check");
    idle(2, "R11 listen");
    step(0, 0, 0, 0, 0, 0, "R11 drain");
    @(negedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule